// File: doc/BRIEF.md
# Three-Wire Register Write Master

This block programs a display driver's internal configuration registers over a synchronous three-wire link. The link has an active-low select line, a serial clock and one data line. The data line is split at the block edge into an output value, an output enable and an input value. A host presents a 6-bit register address, a read flag and 8 bits of write data, and raises a start strobe while the block is not busy. The block then builds one 16-bit frame and shifts it out. For a read, it releases the data line and gathers the 8 bits that the driver returns.

Each frame has a fixed layout. Six address bits come first, then one direction bit, then one turnaround slot, then eight data bits. The driver keeps a frame only if the select line encloses exactly sixteen rising clock edges. The serial clock half period is set in system clock cycles by an input, so one design can serve both slow and fast drivers. After reset, the block walks a parameter table of address/data pairs and writes each of them before it accepts any host request. The driver's pixel clock has to be running while registers are written, and providing it is the system's job.

Top module: `tw_reg_master`

## Requirements
- R1: While rst_ni is low, sen_o and sclk_o are 1, sda_oe_o is 0 and rdata_o is 0.
- R2: A frame opens when sen_o falls with sclk_o already low. sen_o then stays low for exactly 16 serial clock periods, each one low half followed by high half, so each frame holds exactly 16 rising edges of sclk_o.
- R3: Frame bit order is addr[5] down to addr[0], then the direction bit (0 write, 1 read), then the turnaround slot, then data[7] down to data[0].
- R4: sda_o changes only when the serial clock falls or the frame opens. It stays constant for the whole high half of every bit.
- R5: Each half period of sclk_o lasts half_i+1 system clock cycles.
- R6: In a read frame, sda_oe_o is 0 from the turnaround slot to the end of the frame. rdata_o then holds the sda_i values sampled at the 9th through 16th rising edges, with the first one as bit 7.
- R7: In a write frame, the turnaround slot drives 0 with sda_oe_o high.
- R8: After sen_o rises, it stays high for one full serial clock period (two half periods) with busy_o still 1 and sda_oe_o 0. busy_o then drops. A start_i pulse while busy_o is 1 launches nothing.
- R9: After reset, the INIT_N table entries are written in order from entry 0 as write frames. busy_o stays 1 until the last of them completes. Each entry is {addr[5:0], data[7:0]}.
- R10: rdata_o changes only in the cycle where busy_o falls after a read frame. Write frames leave it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_i | input | 8 | Serial clock half period minus one, in clk_i cycles |
| start_i | input | 1 | Request a frame; taken when busy_o is 0 |
| addr_i | input | 6 | Register address |
| rd_i | input | 1 | 1 for read, 0 for write |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Table walk or frame (including idle gap) in progress |
| rdata_o | output | 8 | Data from the last read frame |
| sen_o | output | 1 | Active-low frame select |
| sclk_o | output | 1 | Serial clock, idles high |
| sda_o | output | 1 | Serial data out |
| sda_oe_o | output | 1 | Serial data output enable |
| sda_i | input | 1 | Serial data in from the driver |

## Verification
Any wrong internal position in the frame shows up at once on the pins. A half-step counter that is off by one moves an sclk_o edge, or closes sen_o at the wrong moment, within one half period. A misloaded shift register puts the wrong bit on sda_o at the next falling edge. A wrong capture point or direction decode only shows on rdata_o when busy_o drops, up to a full frame later. For that reason the bench also feeds a distinct byte on every read. A table walk that stalls, or ends early, shows as busy_o holding or releasing too soon once the last init frame has finished.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned ADDR_W       = 6;
  localparam int unsigned DATA_W       = 8;
  localparam int unsigned FRAME_BITS   = ADDR_W + 2 + DATA_W;
  localparam int unsigned HALVES       = 2 * FRAME_BITS;
  localparam int unsigned GAP_HALVES   = 2;
  localparam int unsigned LAST_HALF    = HALVES + GAP_HALVES - 1;
  localparam int unsigned TURN_BIT     = ADDR_W + 1;
  localparam int unsigned IDX_W        = $clog2(LAST_HALF + 1);
  localparam int unsigned INIT_ENTRY_W = ADDR_W + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic [DATA_W-1:0] data;
  } tw_req_t;

  function automatic logic [FRAME_BITS-1:0] pack_frame(tw_req_t r);
    return {r.addr, r.rd, 1'b0, r.data};
  endfunction
endpackage

// File: rtl/tw_clk_div.sv
module tw_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tw_frame_engine.sv
module tw_frame_engine
  import tw_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  tw_req_t           req_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              sda_i,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sen_o,
  output logic              sclk_o,
  output logic              sda_o,
  output logic              sda_oe_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST_HALF);
  localparam logic [IDX_W-1:0] HALF_END = IDX_W'(HALVES);
  localparam logic [IDX_W-2:0] TURN_B   = (IDX_W-1)'(TURN_BIT);

  logic                  active_q, rd_q, tick;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [DATA_W-1:0]     cap_q, rdata_q;
  logic [IDX_W-2:0]      bit_idx;
  logic                  in_frame, last, rise, fall_step;

  tw_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active_q),
    .half_i (half_i),
    .tick_o (tick)
  );

  assign bit_idx   = idx_q[IDX_W-1:1];
  assign in_frame  = idx_q < HALF_END;
  assign last      = tick && (idx_q == LAST_IDX);
  // even index = low half; moving to odd is the rising edge
  assign rise      = tick && !idx_q[0] && in_frame;
  assign fall_step = tick && idx_q[0] && ((idx_q + 1'b1) < HALF_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      idx_q    <= '0;
      frame_q  <= '0;
      cap_q    <= '0;
      rdata_q  <= '0;
    end else if (!active_q) begin
      if (launch_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        frame_q  <= pack_frame(req_i);
        rd_q     <= req_i.rd;
        cap_q    <= '0;
      end
    end else if (tick) begin
      if (last) begin
        active_q <= 1'b0;
        if (rd_q) rdata_q <= cap_q;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
      if (fall_step) frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
      if (rise && rd_q && (bit_idx > TURN_B)) cap_q <= {cap_q[DATA_W-2:0], sda_i};
    end
  end

  assign active_o = active_q;
  assign done_o   = last;
  assign rdata_o  = rdata_q;
  assign sen_o    = !(active_q && in_frame);
  assign sclk_o   = !(active_q && in_frame && !idx_q[0]);
  assign sda_oe_o = active_q && in_frame && !(rd_q && (bit_idx >= TURN_B));
  assign sda_o    = sda_oe_o && frame_q[FRAME_BITS-1];
endmodule

// File: rtl/tw_init_seq.sv
module tw_init_seq
  import tw_pkg::*;
#(
  parameter int unsigned INIT_N = 3,
  parameter logic [INIT_N-1:0][INIT_ENTRY_W-1:0] INIT_TABLE = '0
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    done_i,
  output logic    pending_o,
  output tw_req_t req_o
);
  localparam int unsigned CNT_W = $clog2(INIT_N + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(INIT_N);

  logic [CNT_W-1:0] cnt_q;

  assign pending_o = cnt_q != CNT_END;

  always_comb begin
    req_o = '0;
    for (int i = 0; i < int'(INIT_N); i++) begin
      if (cnt_q == CNT_W'(i)) begin
        req_o.addr = INIT_TABLE[i][INIT_ENTRY_W-1 -: ADDR_W];
        req_o.data = INIT_TABLE[i][DATA_W-1:0];
      end
    end
    req_o.rd = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (done_i && pending_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tw_reg_master.sv
module tw_reg_master
  import tw_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned INIT_N = 3,
  parameter logic [((INIT_N > 0) ? INIT_N : 1)-1:0][INIT_ENTRY_W-1:0] INIT_TABLE =
    {14'h3F81, 14'h2A3C, 14'h11A5}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sen_o,
  output logic              sclk_o,
  output logic              sda_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  logic    active, done, init_pending, launch;
  tw_req_t host_req, init_req, req;

  assign host_req = '{addr: addr_i, rd: rd_i, data: wdata_i};

  if (INIT_N > 0) begin : g_init
    tw_init_seq #(.INIT_N(INIT_N), .INIT_TABLE(INIT_TABLE)) u_init (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .done_i    (done),
      .pending_o (init_pending),
      .req_o     (init_req)
    );
  end else begin : g_no_init
    assign init_pending = 1'b0;
    assign init_req     = '0;
  end

  // table walk owns the link until it finishes
  assign req    = init_pending ? init_req : host_req;
  assign launch = !active && (init_pending || start_i);
  assign busy_o = active || init_pending;

  tw_frame_engine #(.DIV_W(DIV_W)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .req_i    (req),
    .half_i   (half_i),
    .sda_i    (sda_i),
    .active_o (active),
    .done_o   (done),
    .rdata_o  (rdata_o),
    .sen_o    (sen_o),
    .sclk_o   (sclk_o),
    .sda_o    (sda_o),
    .sda_oe_o (sda_oe_o)
  );
endmodule

// File: rtl/tw_checker.sv
module tw_checker
  import tw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sen_o,
  input logic              sclk_o,
  input logic              sda_o,
  input logic              sda_oe_o,
  input logic              busy_o,
  input logic [DATA_W-1:0] rdata_o
);
  logic       sclk_d;
  logic [5:0] rises_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b1;
      rises_q <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (sen_o)                rises_q <= '0;
      else if (sclk_o && !sclk_d) rises_q <= rises_q + 1'b1;
    end
  end

  assert_open_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sen_o) |-> !sclk_o);

  assert_sixteen_rises_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sen_o) |-> (rises_q == 6'd16));

  assert_hold_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sen_o && sclk_o && $past(!sen_o) && $past(sclk_o)) |-> $stable(sda_o));

  assert_gap_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sen_o) |-> (busy_o && !sda_oe_o));

  assert_rdata_update_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $fell(busy_o));
endmodule

bind tw_reg_master tw_checker u_chk (.*);

// File: tb/sim_tw_reg_master.sv
module sim_tw_reg_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half;
  logic       start, rd;
  logic [5:0] addr;
  logic [7:0] wdata;
  logic       sda_i;
  logic       busy, sen, sclk, sda_o, sda_oe;
  logic [7:0] rdata;

  always #2 clk = ~clk;

  tw_reg_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .half_i(half), .start_i(start), .addr_i(addr),
    .rd_i(rd), .wdata_i(wdata), .busy_o(busy), .rdata_o(rdata), .sen_o(sen),
    .sclk_o(sclk), .sda_o(sda_o), .sda_oe_o(sda_oe), .sda_i(sda_i)
  );

  int checks = 0, fails = 0, wd = 0;
  bit finished = 0, armed = 0;
  logic [13:0] tbl [3] = '{14'h11A5, 14'h2A3C, 14'h3F81};
  int exp_q[$];   // bit17 init, bit16 rd, [15:0] frame word

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---- behavioural reference ----
  bit m_active, m_rd, m_init_frame;
  int m_t, m_h, m_init_left, m_ix;
  logic [15:0] m_word;
  logic [7:0]  m_cap, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_t = 0; m_h = 1; m_init_left = 3; m_rdata = 0; m_cap = 0;
      m_rd = 0; m_init_frame = 0; m_word = 0; armed = 0;
    end else begin
      armed = 1;
      if (m_active) begin
        m_t++;
        if (m_t % m_h == 0) begin
          m_ix = m_t / m_h;
          if (m_ix % 2 == 1 && m_ix < 32 && m_rd && m_ix / 2 >= 8) m_cap = {m_cap[6:0], sda_i};
        end
        if (m_t == 34 * m_h) begin
          m_active = 0;
          if (m_rd) m_rdata = m_cap;
          if (m_init_frame) m_init_left--;
        end
      end else if (m_init_left > 0) begin
        m_word = {tbl[3 - m_init_left][13:8], 2'b00, tbl[3 - m_init_left][7:0]};
        m_rd = 0; m_init_frame = 1; m_active = 1; m_t = 0; m_h = int'(half) + 1; m_cap = 0;
      end else if (start) begin
        m_word = {addr, rd, 1'b0, wdata};
        m_rd = rd; m_init_frame = 0; m_active = 1; m_t = 0; m_h = int'(half) + 1; m_cap = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (armed && rst_n && !finished) begin
      int ix, b;
      bit inf, e_sen, e_sclk, e_oe, e_busy;
      ix = m_t / m_h; b = ix / 2;
      inf = m_active && ix < 32;
      e_sen = !inf;
      e_sclk = !(inf && ix % 2 == 0);
      e_oe = inf && !(m_rd && b >= 7);
      e_busy = m_active || m_init_left > 0;
      chk(sen === e_sen, "R2", "sen", sen, e_sen);
      chk(sclk === e_sclk, "R5", "sclk", sclk, e_sclk);
      chk(sda_oe === e_oe, "R6", "sda_oe", sda_oe, e_oe);
      if (e_oe) chk(sda_o === m_word[15 - b], "R4", "sda", sda_o, m_word[15 - b]);
      chk(busy === e_busy, "R8", "busy", busy, e_busy);
      chk(rdata === m_rdata, "R10", "rdata", rdata, m_rdata);
    end
  end

  // ---- slave side of the link ----
  bit s_prev_sclk, s_prev_sen;
  int s_rises;
  logic [15:0] s_bits;
  logic [7:0]  s_resp;

  always @(negedge clk) begin
    if (!rst_n) begin
      s_prev_sclk = 1; s_prev_sen = 1; s_rises = 0; s_bits = 0; sda_i = 0;
    end else begin
      if (!sen && s_prev_sen) begin s_rises = 0; s_bits = 0; end
      if (!sen && sclk && !s_prev_sclk) begin
        s_rises++;
        s_bits = {s_bits[14:0], sda_oe ? sda_o : 1'b0};
      end
      if (!sen && s_rises >= 8 && s_rises < 16) sda_i = s_resp[15 - s_rises];
      else sda_i = 0;
      if (sen && !s_prev_sen && !finished) begin
        chk(s_rises == 16, "R2", "rising edges in frame", s_rises, 16);
        if (exp_q.size() == 0) chk(0, "R8", "unexpected frame", s_bits, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          if (e[16]) chk(s_bits[15:8] === e[15:8], "R3", "read header", s_bits[15:8], e[15:8]);
          else if (e[17]) chk(s_bits === e[15:0], "R9", "init frame", s_bits, e[15:0]);
          else chk(s_bits === e[15:0], "R3", "write frame", s_bits, e[15:0]);
          if (!e[16]) chk(s_bits[8] === 1'b0, "R7", "turnaround", s_bits[8], 0);
        end
      end
      s_prev_sclk = sclk; s_prev_sen = sen;
    end
  end

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !finished) begin
      checks++; fails++;
      $display("FAIL R8 watchdog busy never settled actual=%0d expected=%0d", busy, 0);
      summary();
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy !== 1'b0) @(negedge clk);
  endtask

  task automatic host_frame(input logic [5:0] a, input bit r, input logic [7:0] d,
                            input logic [7:0] resp, input bit poke);
    wait_idle();
    s_resp = resp;
    exp_q.push_back({14'd0, r, a, r, 1'b0, d});
    addr = a; rd = r; wdata = d; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (10) @(negedge clk);
      addr = 6'h3F; rd = 0; wdata = 8'hFF; start = 1;   // must be ignored
      @(negedge clk);
      start = 0;
    end
    wait_idle();
  endtask

  initial begin
    half = 8'd2; start = 0; addr = 0; rd = 0; wdata = 0; s_resp = 0;
    for (int i = 0; i < 3; i++) exp_q.push_back({2'b10, tbl[i][13:8], 2'b00, tbl[i][7:0]});
    repeat (3) @(negedge clk);
    chk(sen === 1'b1, "R1", "sen in reset", sen, 1);
    chk(sclk === 1'b1, "R1", "sclk in reset", sclk, 1);
    chk(sda_oe === 1'b0, "R1", "sda_oe in reset", sda_oe, 0);
    chk(rdata === 8'h00, "R1", "rdata in reset", rdata, 0);
    rst_n = 1;
    wait_idle();
    chk(exp_q.size() == 0, "R9", "init frames outstanding", exp_q.size(), 0);

    host_frame(6'h15, 0, 8'hC3, 8'h00, 0);
    host_frame(6'h2A, 1, 8'h00, 8'h96, 0);
    chk(rdata === 8'h96, "R6", "read data", rdata, 8'h96);
    host_frame(6'h01, 0, 8'h7E, 8'h00, 1);
    @(negedge clk);
    chk(sen === 1'b1, "R8", "start while busy launched frame", sen, 1);
    chk(rdata === 8'h96, "R10", "rdata after write", rdata, 8'h96);
    half = 8'd0;
    host_frame(6'h33, 1, 8'h00, 8'h5A, 0);
    chk(rdata === 8'h5A, "R6", "read data fast clock", rdata, 8'h5A);
    half = 8'd5;
    host_frame(6'h3F, 0, 8'h00, 8'h00, 0);
    host_frame(6'h00, 1, 8'h00, 8'hFF, 0);
    chk(rdata === 8'hFF, "R6", "read data slow clock", rdata, 8'hFF);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "frames outstanding", exp_q.size(), 0);
    summary();
  end
endmodule